// File: doc/BRIEF.md
# Packet Header/Payload Splitter with Padding

This block takes in a byte stream of link packets, where the last byte of each packet carries an end flag. It steers the first few bytes of every packet, the header, into a header/length queue. The remaining bytes, the payload, go into a separate data queue. When the packet ends, the block writes the number of payload bytes it received as one extra entry in the header/length queue, right after that packet's header. It then fills the data queue with zero bytes until the payload reaches a fixed size.

Every packet therefore takes exactly the same number of entries in the data queue. A consumer that sees a header can program a transfer of constant length at once, without waiting for the rest of the packet. Both queues are external. Each is fed through a registered write port that has its own ready signal. If either queue refuses an entry, the input is held off, so no byte is lost or written twice.

Top module: `pkt_splitter`

## Requirements
- R1: The first HDR_BYTES bytes of each packet are written to the header/length queue as entries with the tag bit (MSB of `hq_data`) at 0 and the byte in bits [7:0], in arrival order.
- R2: Payload bytes, meaning every byte after the header, are written to the data queue in arrival order, up to MAX_PAYLOAD bytes per packet.
- R3: After the byte flagged `in_last` is accepted, exactly one entry with the tag bit at 1 is written to the header/length queue, following that packet's header entries. Its low bits hold the count of payload bytes written for that packet. The count excludes header bytes and filler.
- R4: After the payload, the data queue receives 0x00 filler bytes until the packet has written exactly MAX_PAYLOAD entries there.
- R5: In the cycle after the last byte of a packet is accepted, `in_ready` is low. It stays low while the length entry and the filler are being written.
- R6: A packet that ends before HDR_BYTES bytes have arrived still writes its partial header. It then writes a length of 0 and a full MAX_PAYLOAD of filler.
- R7: Payload bytes beyond MAX_PAYLOAD are accepted and discarded. The reported length saturates at MAX_PAYLOAD. `ovf_flag` rises and stays high until reset.
- R8: While an output has valid high and its ready low, that output's valid and data hold steady and `in_ready` is low. Every entry is delivered exactly once.
- R9: Right after reset, both output valids are low, `ovf_flag` is low, and `in_ready` is high when both readies are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a packet |
| hq_valid | output | 1 | Header/length entry present |
| hq_ready | input | 1 | Header/length queue accepts an entry |
| hq_data | output | DW+1 | Tag bit (MSB) and header byte or length |
| dq_valid | output | 1 | Data queue byte present |
| dq_ready | input | 1 | Data queue accepts a byte |
| dq_data | output | 8 | Payload or filler byte |
| ovf_flag | output | 1 | Sticky payload overflow indicator |

## Verification
The assertions check, on every cycle, the following properties:
- Each output holds steady under backpressure.
- A stalled output forces `in_ready` low.
- `in_ready` drops after an end-of-packet byte.
- The overflow flag is sticky.
- No reported length exceeds MAX_PAYLOAD.

Some properties only the bench's scenarios can show, by comparing every delivered entry against a behavioural model:
- The exact order and content of header, length and filler entries.
- The partial-header case.
- Saturation of the count on an oversized packet.
- That no entry is lost under random and long stalls.

// File: rtl/pkt_split_pkg.sv
package pkt_split_pkg;
  typedef enum logic [1:0] {
    ST_HDR = 2'd0,
    ST_PAY = 2'd1,
    ST_LEN = 2'd2,
    ST_PAD = 2'd3
  } split_st_e;
endpackage

// File: rtl/pkt_split_oreg.sv
// One registered write stage; accepts a new entry when empty or draining.
module pkt_split_oreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         rdy,
  output logic         free,
  output logic         valid,
  output logic [W-1:0] data
);
  assign free = !valid || rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (free) begin
      valid <= push;
      if (push) data <= pdata;
    end
  end
endmodule

// File: rtl/pkt_split_ctrl.sv
// Sequencer: header steering, payload count, length entry, filler.
module pkt_split_ctrl
  import pkt_split_pkg::*;
#(
  parameter int HDR_BYTES   = 4,
  parameter int MAX_PAYLOAD = 64,
  parameter int LW          = 7,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          hfree,
  input  logic          dfree,
  output logic          push_h,
  output logic [DW:0]   h_data,
  output logic          push_d,
  output logic [7:0]    d_data,
  output logic          ovf
);
  localparam int HCW = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1;
  localparam logic [HCW-1:0] HLAST = HCW'(HDR_BYTES - 1);
  localparam logic [LW-1:0]  PMAX  = LW'(MAX_PAYLOAD);
  localparam logic [LW-1:0]  PLAST = LW'(MAX_PAYLOAD - 1);

  split_st_e      st;
  logic [HCW-1:0] hcnt;
  logic [LW-1:0]  pcnt;
  logic           acc;

  assign acc = in_valid && in_ready;

  always_comb begin
    in_ready = 1'b0;
    push_h   = 1'b0;
    h_data   = '0;
    push_d   = 1'b0;
    d_data   = '0;
    unique case (st)
      ST_HDR: begin
        in_ready = hfree && dfree;
        push_h   = acc;
        h_data   = {1'b0, DW'(in_data)};
      end
      ST_PAY: begin
        in_ready = hfree && dfree;
        push_d   = acc && (pcnt < PMAX);
        d_data   = in_data;
      end
      ST_LEN: begin
        push_h = hfree;
        h_data = {1'b1, DW'(pcnt)};
      end
      ST_PAD: begin
        push_d = dfree;
        d_data = 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_HDR;
      hcnt <= '0;
      pcnt <= '0;
      ovf  <= 1'b0;
    end else begin
      unique case (st)
        ST_HDR: if (acc) begin
          if (in_last) begin
            st   <= ST_LEN;
            hcnt <= '0;
          end else if (hcnt == HLAST) begin
            st   <= ST_PAY;
            hcnt <= '0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ST_PAY: if (acc) begin
          if (pcnt < PMAX) pcnt <= pcnt + 1'b1;
          else             ovf  <= 1'b1;
          if (in_last) st <= ST_LEN;
        end
        ST_LEN: if (hfree) begin
          if (pcnt == PMAX) begin
            st   <= ST_HDR;
            pcnt <= '0;
          end else begin
            st <= ST_PAD;
          end
        end
        ST_PAD: if (dfree) begin
          if (pcnt == PLAST) begin
            st   <= ST_HDR;
            pcnt <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: st <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/pkt_splitter.sv
module pkt_splitter #(
  parameter  int HDR_BYTES   = 4,
  parameter  int MAX_PAYLOAD = 64,
  localparam int LW          = $clog2(MAX_PAYLOAD + 1),
  localparam int DW          = (LW > 8) ? LW : 8,
  localparam int HW          = DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          hq_valid,
  input  logic          hq_ready,
  output logic [HW-1:0] hq_data,
  output logic          dq_valid,
  input  logic          dq_ready,
  output logic [7:0]    dq_data,
  output logic          ovf_flag
);
  logic          hfree, dfree, push_h, push_d;
  logic [HW-1:0] h_data;
  logic [7:0]    d_data;

  pkt_split_ctrl #(
    .HDR_BYTES(HDR_BYTES), .MAX_PAYLOAD(MAX_PAYLOAD), .LW(LW), .DW(DW)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .hfree(hfree), .dfree(dfree),
    .push_h(push_h), .h_data(h_data), .push_d(push_d), .d_data(d_data),
    .ovf(ovf_flag)
  );

  pkt_split_oreg #(.W(HW)) u_hreg (
    .clk(clk), .rst(rst), .push(push_h), .pdata(h_data), .rdy(hq_ready),
    .free(hfree), .valid(hq_valid), .data(hq_data)
  );

  pkt_split_oreg #(.W(8)) u_dreg (
    .clk(clk), .rst(rst), .push(push_d), .pdata(d_data), .rdy(dq_ready),
    .free(dfree), .valid(dq_valid), .data(dq_data)
  );
endmodule

// File: rtl/pkt_splitter_chk.sv
module pkt_splitter_chk #(
  parameter int MAX_PAYLOAD = 64,
  parameter int DW          = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_last,
  input logic        hq_valid,
  input logic        hq_ready,
  input logic [DW:0] hq_data,
  input logic        dq_valid,
  input logic        dq_ready,
  input logic [7:0]  dq_data,
  input logic        ovf_flag
);
  a_r8_hq_hold: assert property (@(posedge clk) disable iff (rst)
    (hq_valid && !hq_ready) |=> (hq_valid && $stable(hq_data)));

  a_r8_dq_hold: assert property (@(posedge clk) disable iff (rst)
    (dq_valid && !dq_ready) |=> (dq_valid && $stable(dq_data)));

  a_r8_stall_in: assert property (@(posedge clk) disable iff (rst)
    ((hq_valid && !hq_ready) || (dq_valid && !dq_ready)) |-> !in_ready);

  a_r5_eop_stall: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  a_r3_len_range: assert property (@(posedge clk) disable iff (rst)
    (hq_valid && hq_data[DW]) |-> (hq_data[DW-1:0] <= DW'(MAX_PAYLOAD)));
endmodule

bind pkt_splitter pkt_splitter_chk #(.MAX_PAYLOAD(MAX_PAYLOAD), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
  .hq_valid(hq_valid), .hq_ready(hq_ready), .hq_data(hq_data),
  .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_data(dq_data), .ovf_flag(ovf_flag)
);

// File: tb/sim_pkt_splitter.sv
`timescale 1ns/1ps
module sim_pkt_splitter;
  localparam int HDR = 4;
  localparam int MAXP = 64;
  localparam int LW = $clog2(MAXP + 1);
  localparam int DW = (LW > 8) ? LW : 8;
  localparam int HW = DW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, hq_valid, dq_valid, ovf_flag;
  logic hq_ready = 1'b1, dq_ready = 1'b1;
  logic [HW-1:0] hq_data;
  logic [7:0] dq_data;

  always #2.5 clk = ~clk;

  pkt_splitter #(.HDR_BYTES(HDR), .MAX_PAYLOAD(MAXP)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last),
    .hq_valid(hq_valid), .hq_ready(hq_ready), .hq_data(hq_data),
    .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_data(dq_data),
    .ovf_flag(ovf_flag)
  );

  int errs = 0, total = 0;
  logic [HW-1:0] exp_h[$];
  string tag_h[$];
  logic [7:0] exp_d[$];
  string tag_d[$];
  string cur_tag = "";
  bit rnd_en = 1'b0, hold_h = 1'b0, in_acc = 1'b0, exp_ovf = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int b_h = 0, b_p = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string pick(input string dflt);
    return (cur_tag == "") ? dflt : cur_tag;
  endfunction

  // Reference model and per-cycle comparison
  bit ph_st = 0, pd_st = 0, eop_pend = 0;
  logic [HW-1:0] ph_d;
  logic [7:0] pd_d;
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hq_ready = hold_h ? 1'b0 : (rnd_en ? (lfsr[0] | lfsr[3]) : 1'b1);
      dq_ready = rnd_en ? (lfsr[5] | lfsr[9]) : 1'b1;
      #1;
      in_acc = in_valid && in_ready && !rst;
      if (rst) begin
        ph_st = 0; pd_st = 0; eop_pend = 0;
        continue;
      end
      if (eop_pend) chk(!in_ready, "R5", "in_ready after end of packet", in_ready, 0);
      eop_pend = 0;
      if (ph_st) chk(hq_valid && hq_data == ph_d, "R8", "header output held", hq_data, ph_d);
      if (pd_st) chk(dq_valid && dq_data == pd_d, "R8", "data output held", dq_data, pd_d);
      if ((hq_valid && !hq_ready) || (dq_valid && !dq_ready))
        chk(!in_ready, "R8", "in_ready during stall", in_ready, 0);
      ph_st = hq_valid && !hq_ready; ph_d = hq_data;
      pd_st = dq_valid && !dq_ready; pd_d = dq_data;
      if (hq_valid && hq_ready) begin
        if (exp_h.size() == 0) chk(0, "R8", "unexpected header entry", hq_data, 0);
        else begin
          logic [HW-1:0] e;
          string t;
          e = exp_h.pop_front();
          t = tag_h.pop_front();
          chk(hq_data == e, t, "header/length entry", hq_data, e);
        end
      end
      if (dq_valid && dq_ready) begin
        if (exp_d.size() == 0) chk(0, "R8", "unexpected data entry", dq_data, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_d.pop_front();
          t = tag_d.pop_front();
          chk(dq_data == e, t, "data entry", dq_data, e);
        end
      end
      if (in_acc) begin
        if (b_h < HDR) begin
          exp_h.push_back({1'b0, DW'(in_data)}); tag_h.push_back(pick("R1"));
          b_h++;
        end else if (b_p < MAXP) begin
          exp_d.push_back(in_data); tag_d.push_back(pick("R2"));
          b_p++;
        end else begin
          exp_ovf = 1'b1;
        end
        if (in_last) begin
          logic [HW-1:0] e;
          e = '0; e[HW-1] = 1'b1; e[LW-1:0] = LW'(b_p);
          exp_h.push_back(e); tag_h.push_back(pick("R3"));
          for (int k = b_p; k < MAXP; k++) begin
            exp_d.push_back(8'h00); tag_d.push_back(pick("R4"));
          end
          b_h = 0; b_p = 0; eop_pend = 1;
        end
      end
    end
  end

  task automatic send(input int n, input logic [7:0] base, input string tg);
    cur_tag = tg;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(base + i);
      in_last  = (i == n - 1);
      @(posedge clk);
      while (!in_acc) @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain;
    int w = 0;
    while ((exp_h.size() != 0 || exp_d.size() != 0) && w < 5000) begin
      @(posedge clk); w++;
    end
    repeat (3) @(posedge clk);
    cur_tag = "";
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    chk(!hq_valid, "R9", "hq_valid after reset", hq_valid, 0);
    chk(!dq_valid, "R9", "dq_valid after reset", dq_valid, 0);
    chk(!ovf_flag, "R9", "ovf_flag after reset", ovf_flag, 0);
    chk(in_ready,  "R9", "in_ready after reset", in_ready, 1);

    send(14, 8'h10, "");      // 10 payload bytes
    send(HDR + MAXP, 8'h40, "");  // exactly full payload
    send(2, 8'hA0, "R6");     // partial header
    send(HDR, 8'hB0, "");     // header only, length 0
    drain();

    rnd_en = 1'b1;
    send(20, 8'h21, "");
    send(7, 8'h31, "");
    send(1, 8'hC5, "R6");
    send(40, 8'h51, "");
    drain();

    hold_h = 1'b1;
    fork
      send(30, 8'h61, "R8");
      begin repeat (25) @(posedge clk); hold_h = 1'b0; end
    join
    drain();

    chk(ovf_flag == 1'b0, "R7", "ovf_flag before oversize", ovf_flag, 0);
    send(HDR + MAXP + 6, 8'h71, "R7");
    drain();
    chk(ovf_flag == 1'b1, "R7", "ovf_flag after oversize", ovf_flag, 1);
    send(9, 8'h81, "");
    drain();
    chk(ovf_flag == exp_ovf, "R7", "ovf_flag sticky", ovf_flag, exp_ovf);
    rnd_en = 1'b0;
    repeat (4) @(posedge clk);
    chk(exp_h.size() == 0, "R8", "header entries all delivered", exp_h.size(), 0);
    chk(exp_d.size() == 0, "R8", "data entries all delivered", exp_d.size(), 0);

    $display("  Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule